// File: doc/BRIEF.md
# Halfword Store Decode and Execute Unit

This unit takes one store-halfword instruction with an immediate offset and turns it into a 16-bit memory write. The instruction arrives as a 32-bit word with a 2-bit format tag, a condition-passed flag and the two register-file values the instruction names: the base and the data source. Four immediate formats are supported. The first is a full-width format with a split 8-bit immediate and free choice of offset, pre-indexed or post-indexed addressing. The other three are compact formats: a short form with a scaled 5-bit immediate, a wide form with a 12-bit immediate, and an indexed form with an 8-bit immediate.

The unit decodes the immediate and the index, add and writeback controls, and it forms both the offset address and the access address. It holds one request in an output slot. It then presents the write on a valid/ready memory port and returns the new base value on a writeback strobe. Illegal encodings, encodings that belong to the unprivileged store variant, operand combinations with no defined result, and misaligned accesses are all reported on registered flags. These flags appear together with the decoded controls, so that a pipeline or a reference model can follow each instruction.

Top module: `hstore_unit`

## Requirements
- R1: Format tag 0 selects the full-width form. In this form P is bit 24, U is bit 23, W is bit 21, the base number is bits 19:16, the data number is bits 15:12, and the immediate is bits 11:8 concatenated with bits 3:0, zero-extended. index = P, add = U, and writeback = (not P) or W.
- R2: In the full-width form, P=0 together with W=1 raises fltRedirect. No store and no writeback follow.
- R3: Format tag 1 selects the short form. The immediate is bits 10:6 shifted left by one. The base number is bits 5:3 and the data number is bits 2:0. The access is always pre-indexed and added, with no writeback.
- R4: Format tag 2 selects the wide compact form. The base number is bits 19:16, the data number is bits 15:12 and the immediate is bits 11:0. The access is pre-indexed and added, with no writeback. A base number of 15 raises fltUndef, and no store follows.
- R5: Format tag 3 selects the 8-bit compact form. The base number is bits 19:16, the data number is bits 15:12, P is bit 10, U is bit 9, W is bit 8 and the immediate is bits 7:0. index = P, add = U and writeback = W. P=1, U=1, W=0 raises fltRedirect, which takes priority. Otherwise, base 15 or P=0 with W=0 raises fltUndef.
- R6: The offset address is base + immediate when add is set and base − immediate otherwise, modulo 2^XLEN. memAddr is the offset address when index is set and the unmodified base otherwise.
- R7: memData carries bits 15:0 of the data value and memStrb is 2'b11. When writeback is set, wbValue is the offset address and wbReg is the base number.
- R8: fltUnpred is raised in the following cases, provided no undefined or redirect flag is raised. The data number is 15. In the full-width form, writeback is set with the base equal to 15 or to the data number. In the 8-bit form, writeback is set with the base equal to the data number. The store still takes place.
- R9: When condPass is low, neither a memory write nor a writeback takes place.
- R10: An accepted instruction is shown on resValid one cycle after acceptance. memValid is held with a stable address and data until memReady. wbEn fires only in the cycle in which the write is accepted. instReady is low while a held request is not retiring.
- R11: When alignChk is high and the access address has bit 0 set, fltAlign is raised. Neither the store nor the writeback takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Unit can take an instruction |
| encSel | input | 2 | Format tag (0 full, 1 short, 2 wide, 3 8-bit) |
| instWord | input | 32 | Instruction word |
| condPass | input | 1 | Condition check passed |
| alignChk | input | 1 | Enable halfword alignment checking |
| baseVal | input | XLEN | Base register value |
| dataVal | input | XLEN | Data register value |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts request |
| memAddr | output | XLEN | Byte address |
| memData | output | 16 | Write data |
| memStrb | output | 2 | Byte lane strobes |
| wbEn | output | 1 | Base register writeback strobe |
| wbReg | output | 4 | Base register number |
| wbValue | output | XLEN | Writeback value |
| resValid | output | 1 | Slot holds a decoded instruction |
| resDone | output | 1 | Slot retires this cycle |
| decIndex | output | 1 | Decoded index control |
| decAdd | output | 1 | Decoded add control |
| decWback | output | 1 | Decoded writeback control |
| fltUndef | output | 1 | Undefined encoding |
| fltUnpred | output | 1 | Unpredictable operands |
| fltRedirect | output | 1 | Encoding belongs to unprivileged variant |
| fltAlign | output | 1 | Alignment fault |

## Verification
On every cycle, the assertions check the following. A request is held stable until the memory accepts it. The writeback strobe appears only with an accepted write. Undefined, redirect and alignment faults never produce a write or writeback. A pre-indexed writeback equals the access address. At most one fault class is flagged at a time. Only the bench's scenarios can show that each format extracts its immediate and fields correctly, that the add/subtract and post-index address choices are right, and that a failed condition suppresses everything. These scenarios also cover which operand combinations are flagged unpredictable; the bench compares each retired instruction against an independent decode model.

// File: rtl/hstore_pkg.sv
package hstore_pkg;
  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_SHORT = 2'd1,
    FMT_IMM12 = 2'd2,
    FMT_IMM8  = 2'd3
  } fmtE;

  localparam int IMM_W = 12;
  localparam int REG_W = 4;
  localparam int HALF_W = 16;
  localparam int LANES = HALF_W / 8;

  typedef struct packed {
    logic capture;
    logic index;
    logic add;
  } dpStbT;
endpackage

// File: rtl/hstore_ctrl.sv
module hstore_ctrl
  import hstore_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  output logic                instReady,
  input  logic [1:0]          encSel,
  input  logic [31:0]         instWord,
  input  logic                condPass,
  input  logic                alignChk,
  input  logic                accLsb,
  input  logic                memReady,
  output dpStbT               stb,
  output logic [IMM_W-1:0]    imm,
  output logic                memValid,
  output logic                wbEn,
  output logic [REG_W-1:0]    wbReg,
  output logic                resValid,
  output logic                resDone,
  output logic                decIndex,
  output logic                decAdd,
  output logic                decWback,
  output logic                fltUndef,
  output logic                fltUnpred,
  output logic                fltRedirect,
  output logic                fltAlign
);
  logic idx, add, wb, undef, redir, unp;
  logic [REG_W-1:0] rn, rt;
  logic exec, alignF, doStore, doWb, accept, retire;
  logic busy, storeQ, wbQ;
  logic unusedBits;

  assign unusedBits = ^{instWord[31:25], instWord[22], instWord[20]};

  always_comb begin
    imm = '0; idx = 1'b1; add = 1'b1; wb = 1'b0;
    undef = 1'b0; redir = 1'b0; unp = 1'b0;
    rn = instWord[19:16]; rt = instWord[15:12];
    case (fmtE'(encSel))
      FMT_FULL: begin
        imm   = {4'b0, instWord[11:8], instWord[3:0]};
        idx   = instWord[24];
        add   = instWord[23];
        wb    = !instWord[24] || instWord[21];
        redir = !instWord[24] && instWord[21];
        unp   = (rt == 4'hF) || (wb && (rn == 4'hF || rn == rt));
      end
      FMT_SHORT: begin
        imm = {6'b0, instWord[10:6], 1'b0};
        rn  = {1'b0, instWord[5:3]};
        rt  = {1'b0, instWord[2:0]};
      end
      FMT_IMM12: begin
        imm   = instWord[11:0];
        undef = (rn == 4'hF);
        unp   = (rt == 4'hF);
      end
      default: begin
        imm   = {4'b0, instWord[7:0]};
        idx   = instWord[10];
        add   = instWord[9];
        wb    = instWord[8];
        redir = idx && add && !wb;
        undef = !redir && ((rn == 4'hF) || (!idx && !wb));
        unp   = (rt == 4'hF) || (wb && rn == rt);
      end
    endcase
  end

  assign exec    = condPass && !undef && !redir;
  assign alignF  = exec && alignChk && accLsb;
  assign doStore = exec && !alignF;
  assign doWb    = doStore && wb;

  assign retire    = busy && (!storeQ || memReady);
  assign instReady = !busy || retire;
  assign accept    = instValid && instReady;

  assign stb.capture = accept;
  assign stb.index   = idx;
  assign stb.add     = add;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; storeQ <= 1'b0; wbQ <= 1'b0; wbReg <= '0;
      decIndex <= 1'b0; decAdd <= 1'b0; decWback <= 1'b0;
      fltUndef <= 1'b0; fltUnpred <= 1'b0; fltRedirect <= 1'b0; fltAlign <= 1'b0;
    end else if (accept) begin
      busy        <= 1'b1;
      storeQ      <= doStore;
      wbQ         <= doWb;
      wbReg       <= rn;
      decIndex    <= idx;
      decAdd      <= add;
      decWback    <= wb;
      fltUndef    <= undef;
      fltRedirect <= redir;
      fltUnpred   <= unp && !undef && !redir;
      fltAlign    <= alignF;
    end else if (retire) begin
      busy <= 1'b0; storeQ <= 1'b0; wbQ <= 1'b0;
    end
  end

  assign memValid = busy && storeQ;
  assign wbEn     = busy && storeQ && wbQ && memReady;
  assign resValid = busy;
  assign resDone  = retire;
endmodule

// File: rtl/hstore_dp.sv
module hstore_dp
  import hstore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStbT             stb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   dataVal,
  output logic              accLsb,
  output logic [XLEN-1:0]   memAddr,
  output logic [HALF_W-1:0] memData,
  output logic [XLEN-1:0]   wbValue
);
  localparam int PAD_W = XLEN - IMM_W;
  logic [XLEN-1:0] immX, offAddr, accAddr;
  logic unusedHi;

  assign unusedHi = ^dataVal[XLEN-1:HALF_W];
  assign immX     = {{PAD_W{1'b0}}, imm};
  assign offAddr  = stb.add ? (baseVal + immX) : (baseVal - immX);
  assign accAddr  = stb.index ? offAddr : baseVal;
  assign accLsb   = accAddr[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0; memData <= '0; wbValue <= '0;
    end else if (stb.capture) begin
      memAddr <= accAddr;
      memData <= dataVal[HALF_W-1:0];
      wbValue <= offAddr;
    end
  end
endmodule

// File: rtl/hstore_unit.sv
module hstore_unit
  import hstore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [1:0]        encSel,
  input  logic [31:0]       instWord,
  input  logic              condPass,
  input  logic              alignChk,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [XLEN-1:0]   dataVal,
  output logic              memValid,
  input  logic              memReady,
  output logic [XLEN-1:0]   memAddr,
  output logic [15:0]       memData,
  output logic [1:0]        memStrb,
  output logic              wbEn,
  output logic [3:0]        wbReg,
  output logic [XLEN-1:0]   wbValue,
  output logic              resValid,
  output logic              resDone,
  output logic              decIndex,
  output logic              decAdd,
  output logic              decWback,
  output logic              fltUndef,
  output logic              fltUnpred,
  output logic              fltRedirect,
  output logic              fltAlign
);
  dpStbT stb;
  logic [IMM_W-1:0] imm;
  logic accLsb;

  hstore_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .encSel(encSel), .instWord(instWord), .condPass(condPass),
    .alignChk(alignChk), .accLsb(accLsb), .memReady(memReady),
    .stb(stb), .imm(imm), .memValid(memValid), .wbEn(wbEn), .wbReg(wbReg),
    .resValid(resValid), .resDone(resDone), .decIndex(decIndex),
    .decAdd(decAdd), .decWback(decWback), .fltUndef(fltUndef),
    .fltUnpred(fltUnpred), .fltRedirect(fltRedirect), .fltAlign(fltAlign)
  );

  hstore_dp #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .imm(imm), .baseVal(baseVal),
    .dataVal(dataVal), .accLsb(accLsb), .memAddr(memAddr),
    .memData(memData), .wbValue(wbValue)
  );

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      assign memStrb[ln] = memValid;
    end
  endgenerate
endmodule

// File: rtl/hstore_unit_chk.sv
module hstore_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            instReady,
  input logic            memValid,
  input logic            memReady,
  input logic [XLEN-1:0] memAddr,
  input logic [15:0]     memData,
  input logic            wbEn,
  input logic [XLEN-1:0] wbValue,
  input logic            resValid,
  input logic            resDone,
  input logic            decIndex,
  input logic            fltUndef,
  input logic            fltUnpred,
  input logic            fltRedirect,
  input logic            fltAlign
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  a_r10_wb_with_store: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> memValid && memReady);

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resDone |-> !instReady);

  a_r2_no_store_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (fltUndef || fltRedirect) |-> !memValid && !wbEn);

  a_r11_align_blocks: assert property (@(posedge clk) disable iff (!rstN)
    resValid && fltAlign |-> !memValid && !wbEn && memAddr[0]);

  a_r6_preidx_wb: assert property (@(posedge clk) disable iff (!rstN)
    wbEn && decIndex |-> wbValue == memAddr);

  a_r8_one_fault: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $onehot0({fltUndef, fltRedirect, fltUnpred}));
endmodule

bind hstore_unit hstore_unit_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/hstore_unit_tb_top.sv
module hstore_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0, instReady;
  logic [1:0] encSel = '0;
  logic [31:0] instWord = '0;
  logic condPass = 1'b0, alignChk = 1'b0;
  logic [XLEN-1:0] baseVal = '0, dataVal = '0;
  logic memValid, memReady = 1'b0;
  logic [XLEN-1:0] memAddr, wbValue;
  logic [15:0] memData;
  logic [1:0] memStrb;
  logic wbEn, resValid, resDone, decIndex, decAdd, decWback;
  logic fltUndef, fltUnpred, fltRedirect, fltAlign;
  logic [3:0] wbReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  hstore_unit #(.XLEN(XLEN)) dut_i (.*);

  typedef struct {
    string tag;
    logic [6:0] flags;
    logic st;
    logic [XLEN-1:0] addr;
    logic [15:0] data;
    logic wb;
    logic [3:0] rn;
    logic [XLEN-1:0] wbv;
  } expT;

  expT q[$];
  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic expT model(string tag, logic [1:0] f, logic [31:0] w,
                                logic cp, logic ac, logic [XLEN-1:0] b, logic [XLEN-1:0] d);
    expT e;
    logic p, u, wr, ix, ad, wbk, ud, rd, up, al, ex;
    logic [3:0] rn, rt;
    logic [XLEN-1:0] im, off, acc;
    p = w[24]; u = w[23]; wr = w[21];
    rn = w[19:16]; rt = w[15:12];
    ud = 0; rd = 0; up = 0; ix = 1; ad = 1; wbk = 0;
    if (f == 2'd0) begin
      im = XLEN'({w[11:8], w[3:0]});
      ix = p; ad = u; wbk = !p | wr; rd = !p & wr;
      up = (rt == 15) | (wbk & ((rn == 15) | (rn == rt)));
    end else if (f == 2'd1) begin
      im = XLEN'(w[10:6]) * 2;
      rn = {1'b0, w[5:3]}; rt = {1'b0, w[2:0]};
    end else if (f == 2'd2) begin
      im = XLEN'(w[11:0]);
      ud = (rn == 15); up = (rt == 15);
    end else begin
      im = XLEN'(w[7:0]);
      ix = w[10]; ad = w[9]; wbk = w[8];
      if (ix & ad & !wbk) rd = 1;
      else ud = (rn == 15) | (!ix & !wbk);
      up = (rt == 15) | (wbk & (rn == rt));
    end
    if (ud | rd) up = 0;
    off = ad ? b + im : b - im;
    acc = ix ? off : b;
    ex = cp & !ud & !rd;
    al = ex & ac & acc[0];
    e.tag = tag;
    e.flags = {ud, up, rd, al, ix, ad, wbk};
    e.st = ex & !al;
    e.addr = acc; e.data = d[15:0];
    e.wb = e.st & wbk; e.rn = rn; e.wbv = off;
    return e;
  endfunction

  task automatic issue(string tag, logic [1:0] f, logic [31:0] w, logic cp, logic ac,
                       logic [XLEN-1:0] b, logic [XLEN-1:0] d);
    q.push_back(model(tag, f, w, cp, ac, b, d));
    @(negedge clk); #2;
    instValid = 1; encSel = f; instWord = w; condPass = cp; alignChk = ac;
    baseVal = b; dataVal = d;
    while (!instReady) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    instValid = 0;
  endtask

  function automatic logic [31:0] wFull(logic p, logic u, logic w, logic [3:0] rn,
                                        logic [3:0] rt, logic [7:0] im);
    return {4'hE, 3'b000, p, u, 1'b1, w, 1'b0, rn, rt, im[7:4], 4'b1011, im[3:0]};
  endfunction
  function automatic logic [31:0] wShort(logic [4:0] im, logic [2:0] rn, logic [2:0] rt);
    return {16'h0, 5'b10000, im, rn, rt};
  endfunction
  function automatic logic [31:0] w12(logic [3:0] rn, logic [3:0] rt, logic [11:0] im);
    return {12'hF8A, rn, rt, im};
  endfunction
  function automatic logic [31:0] w8(logic [3:0] rn, logic [3:0] rt, logic p, logic u,
                                     logic w, logic [7:0] im);
    return {12'hF82, rn, rt, 1'b1, p, u, w, im};
  endfunction

  // Monitor: memory ready pattern and scoreboard comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memReady = (cyc % 4) != 1;
      #1;
      if (rstN && resDone) begin
        if (q.size() == 0) begin
          chk("R10", "unexpected retire", 1, 0);
        end else begin
          expT e;
          e = q.pop_front();
          chk(e.tag, "flags", {57'b0, fltUndef, fltUnpred, fltRedirect, fltAlign,
              decIndex, decAdd, decWback}, {57'b0, e.flags});
          chk(e.tag, "store", {63'b0, memValid && memReady}, {63'b0, e.st});
          chk(e.tag, "wbEn", {63'b0, wbEn}, {63'b0, e.wb});
          if (e.st) begin
            chk(e.tag, "addr", 64'(memAddr), 64'(e.addr));
            chk("R7", "data", 64'(memData), 64'(e.data));
            chk("R7", "strb", 64'(memStrb), 64'd3);
          end
          if (e.wb) begin
            chk(e.tag, "wbValue", 64'(wbValue), 64'(e.wbv));
            chk("R7", "wbReg", 64'(wbReg), 64'(e.rn));
          end
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R10", "reset memValid", {63'b0, memValid}, 0);
    chk("R10", "reset resValid", {63'b0, resValid}, 0);
    chk("R10", "reset instReady", {63'b0, instReady}, 1);
    rstN = 1;
    // R1 full-width offset, pre-index subtract with writeback, post-index
    issue("R1", 2'd0, wFull(1, 1, 0, 4'd2, 4'd3, 8'h34), 1, 0, 32'h1000, 32'hA5A51234);
    issue("R1", 2'd0, wFull(1, 0, 1, 4'd4, 4'd5, 8'h10), 1, 1, 32'h2000, 32'h0000BEEF);
    issue("R6", 2'd0, wFull(0, 1, 0, 4'd6, 4'd7, 8'h22), 1, 0, 32'h3000, 32'h00001111);
    // R2 redirect
    issue("R2", 2'd0, wFull(0, 1, 1, 4'd6, 4'd7, 8'h22), 1, 0, 32'h3000, 32'h2222);
    // R8 unpredictable cases still store
    issue("R8", 2'd0, wFull(1, 1, 0, 4'd1, 4'd15, 8'h02), 1, 0, 32'h40, 32'h3333);
    issue("R8", 2'd0, wFull(1, 1, 1, 4'd9, 4'd9, 8'h04), 1, 0, 32'h80, 32'h4444);
    issue("R8", 2'd0, wFull(0, 0, 0, 4'd15, 4'd2, 8'h04), 1, 0, 32'h80, 32'h4545);
    // R3 short form maximum immediate
    issue("R3", 2'd1, wShort(5'd31, 3'd1, 3'd2), 1, 1, 32'h100, 32'h5555);
    // R4 wide compact maximum immediate, odd address without check
    issue("R4", 2'd2, w12(4'd3, 4'd4, 12'hFFF), 1, 0, 32'h10000, 32'h6666);
    // R11 same with alignment checking
    issue("R11", 2'd2, w12(4'd3, 4'd4, 12'hFFF), 1, 1, 32'h10000, 32'h6666);
    issue("R4", 2'd2, w12(4'd15, 4'd4, 12'h010), 1, 0, 32'h10000, 32'h6767);
    // R5 8-bit compact forms
    issue("R5", 2'd3, w8(4'd2, 4'd3, 1, 0, 0, 8'hFF), 1, 0, 32'h500, 32'h7777);
    issue("R5", 2'd3, w8(4'd2, 4'd3, 0, 1, 1, 8'h04), 1, 1, 32'h8000, 32'h8888);
    issue("R5", 2'd3, w8(4'd2, 4'd3, 0, 1, 0, 8'h04), 1, 0, 32'h8000, 32'h8989);
    issue("R5", 2'd3, w8(4'd15, 4'd3, 1, 1, 0, 8'h04), 1, 0, 32'h8000, 32'h9999);
    issue("R5", 2'd3, w8(4'd15, 4'd3, 1, 0, 1, 8'h04), 1, 0, 32'h8000, 32'h9A9A);
    issue("R8", 2'd3, w8(4'd5, 4'd5, 1, 1, 1, 8'h06), 1, 0, 32'h900, 32'hAAAA);
    // R9 condition failed on a writeback form
    issue("R9", 2'd0, wFull(1, 0, 1, 4'd4, 4'd5, 8'h10), 0, 0, 32'h2000, 32'hBBBB);
    issue("R9", 2'd3, w8(4'd1, 4'd3, 0, 0, 1, 8'h08), 0, 1, 32'h2001, 32'hBCBC);
    // R6 wrap below zero, R7 upper data bits dropped
    issue("R6", 2'd3, w8(4'd1, 4'd3, 1, 0, 1, 8'h10), 1, 0, 32'h4, 32'hDEADBEEF);
    issue("R10", 2'd1, wShort(5'd0, 3'd0, 3'd1), 1, 0, 32'hFFFFFFFE, 32'hCAFE);
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R10", "idle memValid", {63'b0, memValid}, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule